// File: doc/BRIEF.md
# Configurable Sum-of-Products Macrocell Array

The block is a synthesizable model of a small programmable logic device built around a sum-of-products structure. A serially loaded configuration register holds the connection bits of an AND array, two global mode bits, one local mode bit per output cell and one polarity bit per output cell. The AND array sees the true and the complemented copy of every array signal: ten dedicated inputs, two dual-use auxiliary inputs and eight feedback lines. It forms sixty-four product terms, eight for each of eight output cells, and each cell ORs its own group.

Each output cell can act as a clocked register, as a combinational cell with a product-term-driven enable, as an always-driven combinational output, or as a pure input whose pin value is fed back into the array. The two global bits pick the family of modes for the whole device and the local bit picks the mode of one cell. Pins are modelled as separate value, enable and pad-sense ports, so the surrounding logic resolves the tri-state. Every cell output passes through one register clocked by the system clock. In the registered mode that register is the cell's flip-flop and loads only when the auxiliary clock input is high. The output registers are cleared by reset and can be preloaded from a test port.

Top module: `pla_macro_array`

## Requirements
- R1: While `prog_en` is 1, each clock edge shifts `prog_sdi` into the configuration register so that the n-th bit shifted (n counted from 0) lands in configuration bit n after 2578 shifts. Bits 0..2559 are connection bits (term t, line l at index t*40+l; 1 = connected), bits 2560+i are the polarity bits of cell i, bits 2568+i are the local bits and bits 2577:2576 the global select.
- R2: From the clock edge after `prog_en` is sampled at 1, `pad_oe` is all zero for as long as `prog_en` stays at 1.
- R3: Product term t is the AND of all array lines whose connection bit is 1. A term with every bit at 1 evaluates to 0 and a term with every bit at 0 evaluates to 1. Cell i owns terms 8i..8i+7 and its first-owned term is term 8i.
- R4: Array signal s drives line 2s (true) and line 2s+1 (complement). Signals 0..9 are `din[9:0]`, 10 is `pin_ck`, 11 is `pin_oen` and 12+i is the feedback of cell i.
- R5: Global select 2'b01 is the registered family, 2'b10 the wide-I/O family, and 2'b00 or 2'b11 the simple family.
- R6: In the registered family a cell with local bit 1 is registered. Its output loads the OR of its 8 terms XOR its polarity bit on edges where `pin_ck` is 1 and holds otherwise. Its feedback is its register value, and its `pad_oe` bit follows the inverse of `pin_oen` one edge later. In this family signals 10 and 11 read 0 in the array.
- R7: A cell with local bit 0 in the registered family, and every cell in the wide-I/O family, is combinational I/O. Its first-owned term is its enable, its value is the OR of its other 7 terms XOR polarity, loaded every edge, and its feedback is `pad_in[i]`.
- R8: In the simple family, an outer cell (not 3 or 4) with local bit 1 is a dedicated input with `pad_oe` 0 and feedback `pad_in[i]`. With local bit 0 it is an always-enabled combinational output over all 8 terms, with feedback `pad_in[i]`.
- R9: In the simple family, cells 3 and 4 ignore their local bit, are always-enabled combinational outputs, and their feedback lines read 0.
- R10: A polarity bit of 1 inverts the cell value and 0 passes it unchanged.
- R11: A clock edge with `preload_en` at 1 loads `preload_val` into the output registers in any mode, and the value appears on `pad_out` after that edge.
- R12: A clock edge with `rst` at 1 clears `pad_out` and `pad_oe` to zero; outputs reflect inputs of the preceding edge (one register stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| prog_en | input | 1 | Configuration shift enable |
| prog_sdi | input | 1 | Configuration serial data |
| din | input | 10 | Dedicated array inputs |
| pin_ck | input | 1 | Register load strobe in the registered family, array input otherwise |
| pin_oen | input | 1 | Active-low shared enable in the registered family, array input otherwise |
| preload_en | input | 1 | Test preload strobe |
| preload_val | input | 8 | Test preload value |
| pad_in | input | 8 | Resolved pin values sensed back from the pads |
| pad_out | output | 8 | Cell output values |
| pad_oe | output | 8 | Cell output enables |

## Verification
The bench goes after the fixed-value terms: a term with all connections made must read 0 and one with none must read 1. A design that treated an empty term as 0 would silence the cells built on it. It drives the centre cells of the simple family with their local bit set and a pin value of 1 on their pads. A design that honoured that bit would float those outputs, and one that routed their pads back would flip the cell that reads their feedback. In the registered family it holds the load strobe low and raises the active-low enable. A design that loaded every edge, or leaked the dual-use pins into the array, would diverge from the bench's model within a few cycles. Preload during random traffic and the all-zero enables during shifting catch a wrong priority or a missing high-impedance hold.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    GM_SIMPLE = 2'd0,
    GM_SEQ    = 2'd1,
    GM_WIDE   = 2'd2
  } gmode_e;

  typedef enum logic [1:0] {
    CM_REG  = 2'd0,
    CM_CIO  = 2'd1,
    CM_COUT = 2'd2,
    CM_DIN  = 2'd3
  } cmode_e;

  function automatic gmode_e decode_gmode(input logic [1:0] gsel);
    gmode_e m;
    case (gsel)
      2'b01:   m = GM_SEQ;
      2'b10:   m = GM_WIDE;
      default: m = GM_SIMPLE;
    endcase
    return m;
  endfunction

  function automatic cmode_e cell_mode(input gmode_e gm, input logic loc_bit, input logic centre);
    cmode_e c;
    case (gm)
      GM_SEQ:  c = loc_bit ? CM_REG : CM_CIO;
      GM_WIDE: c = CM_CIO;
      default: c = (loc_bit && !centre) ? CM_DIN : CM_COUT;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pla_cfg_shift.sv
module pla_cfg_shift #(
  parameter int CFG_BITS = 2578
) (
  input  logic                clk,
  input  logic                prog_en,
  input  logic                prog_sdi,
  output logic [CFG_BITS-1:0] cfg
);

  always_ff @(posedge clk) begin
    if (prog_en) begin
      cfg <= {prog_sdi, cfg[CFG_BITS-1:1]};
    end
  end

endmodule

// File: rtl/pla_and_array.sv
module pla_and_array #(
  parameter int N_LINE = 40,
  parameter int N_PT   = 64
) (
  input  logic [N_LINE*N_PT-1:0] fuse,
  input  logic [N_LINE-1:0]      lines,
  output logic [N_PT-1:0]        pt
);

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    logic [N_LINE-1:0] row;
    assign row   = fuse[t*N_LINE +: N_LINE];
    assign pt[t] = &(~row | lines);
  end

endmodule

// File: rtl/pla_macrocell.sv
module pla_macrocell
  import pla_pkg::*;
#(
  parameter int PT_PER_MC = 8,
  parameter bit IS_CENTRE = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 prog_en,
  input  cmode_e               cmode,
  input  logic                 pol,
  input  logic [PT_PER_MC-1:0] pt,
  input  logic                 pin_ck,
  input  logic                 pin_oen,
  input  logic                 pre_en,
  input  logic                 pre_val,
  input  logic                 pad_in,
  output logic                 q,
  output logic                 oe,
  output logic                 fb
);

  logic sum;
  logic d;
  logic load;

  always_comb begin
    sum  = (cmode == CM_CIO) ? |pt[PT_PER_MC-1:1] : |pt;
    d    = sum ^ pol;
    load = (cmode == CM_REG) ? pin_ck : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q  <= 1'b0;
      oe <= 1'b0;
    end else begin
      if (pre_en) begin
        q <= pre_val;
      end else if (load) begin
        q <= d;
      end
      if (prog_en) begin
        oe <= 1'b0;
      end else begin
        case (cmode)
          CM_REG:  oe <= ~pin_oen;
          CM_CIO:  oe <= pt[0];
          CM_COUT: oe <= 1'b1;
          default: oe <= 1'b0;
        endcase
      end
    end
  end

  always_comb begin
    case (cmode)
      CM_REG:  fb = q;
      CM_COUT: fb = IS_CENTRE ? 1'b0 : pad_in;
      default: fb = pad_in;
    endcase
  end

endmodule

// File: rtl/pla_macro_array.sv
module pla_macro_array
  import pla_pkg::*;
#(
  parameter int N_DIN     = 10,
  parameter int N_MC      = 8,
  parameter int PT_PER_MC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prog_en,
  input  logic            prog_sdi,
  input  logic [N_DIN-1:0] din,
  input  logic            pin_ck,
  input  logic            pin_oen,
  input  logic            preload_en,
  input  logic [N_MC-1:0] preload_val,
  input  logic [N_MC-1:0] pad_in,
  output logic [N_MC-1:0] pad_out,
  output logic [N_MC-1:0] pad_oe
);

  localparam int N_SIG     = N_DIN + 2 + N_MC;
  localparam int N_LINE    = 2 * N_SIG;
  localparam int N_PT      = N_MC * PT_PER_MC;
  localparam int FUSE_BITS = N_LINE * N_PT;
  localparam int POL_LSB   = FUSE_BITS;
  localparam int LOC_LSB   = POL_LSB + N_MC;
  localparam int GSEL_LSB  = LOC_LSB + N_MC;
  localparam int CFG_BITS  = GSEL_LSB + 2;
  localparam int CTR_LO    = N_MC / 2 - 1;
  localparam int CTR_HI    = N_MC / 2;

  logic [CFG_BITS-1:0] cfg;
  logic [N_MC-1:0]     cfg_pol;
  logic [N_MC-1:0]     cfg_loc;
  logic [1:0]          cfg_gsel;
  gmode_e              gmode;
  logic                seq_mode;
  logic [N_MC-1:0]     fb;
  logic [N_SIG-1:0]    sig;
  logic [N_LINE-1:0]   lines;
  logic [N_PT-1:0]     pt;

  pla_cfg_shift #(.CFG_BITS(CFG_BITS)) u_cfg (
    .clk      (clk),
    .prog_en  (prog_en),
    .prog_sdi (prog_sdi),
    .cfg      (cfg)
  );

  assign cfg_pol  = cfg[POL_LSB +: N_MC];
  assign cfg_loc  = cfg[LOC_LSB +: N_MC];
  assign cfg_gsel = cfg[GSEL_LSB +: 2];
  assign gmode    = decode_gmode(cfg_gsel);
  assign seq_mode = (gmode == GM_SEQ);

  assign sig = {fb, pin_oen & ~seq_mode, pin_ck & ~seq_mode, din};

  for (genvar s = 0; s < N_SIG; s++) begin : g_line
    assign lines[2*s]   = sig[s];
    assign lines[2*s+1] = ~sig[s];
  end

  pla_and_array #(.N_LINE(N_LINE), .N_PT(N_PT)) u_and (
    .fuse  (cfg[FUSE_BITS-1:0]),
    .lines (lines),
    .pt    (pt)
  );

  for (genvar g = 0; g < N_MC; g++) begin : g_cell
    localparam bit CTR = (g == CTR_LO) || (g == CTR_HI);
    cmode_e cm;
    assign cm = cell_mode(gmode, cfg_loc[g], CTR);

    pla_macrocell #(.PT_PER_MC(PT_PER_MC), .IS_CENTRE(CTR)) u_mc (
      .clk     (clk),
      .rst     (rst),
      .prog_en (prog_en),
      .cmode   (cm),
      .pol     (cfg_pol[g]),
      .pt      (pt[g*PT_PER_MC +: PT_PER_MC]),
      .pin_ck  (pin_ck),
      .pin_oen (pin_oen),
      .pre_en  (preload_en),
      .pre_val (preload_val[g]),
      .pad_in  (pad_in[g]),
      .q       (pad_out[g]),
      .oe      (pad_oe[g]),
      .fb      (fb[g])
    );
  end

endmodule

// File: rtl/pla_macro_array_chk.sv
module pla_macro_array_chk #(
  parameter int N_MC = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            prog_en,
  input logic            pin_ck,
  input logic            pin_oen,
  input logic            preload_en,
  input logic [N_MC-1:0] preload_val,
  input logic [N_MC-1:0] pad_out,
  input logic [N_MC-1:0] pad_oe,
  input logic [1:0]      cfg_gsel,
  input logic [N_MC-1:0] cfg_loc
);

  logic simple_fam;
  assign simple_fam = (cfg_gsel == 2'b00) || (cfg_gsel == 2'b11);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pad_out == '0 && pad_oe == '0)); // R12

  AST_PROG_HIZ: assert property (@(posedge clk) disable iff (rst)
    prog_en |=> (pad_oe == '0)); // R2

  AST_PRELOAD_LOAD: assert property (@(posedge clk) disable iff (rst)
    preload_en |=> (pad_out == $past(preload_val))); // R11

  for (genvar g = 0; g < N_MC; g++) begin : g_chk
    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
      (cfg_gsel == 2'b01 && cfg_loc[g] && !pin_ck && !preload_en && !prog_en)
      |=> $stable(pad_out[g])); // R6

    AST_REG_OE: assert property (@(posedge clk) disable iff (rst)
      (cfg_gsel == 2'b01 && cfg_loc[g] && !prog_en)
      |=> (pad_oe[g] == !$past(pin_oen))); // R6

    if ((g == N_MC/2-1) || (g == N_MC/2)) begin : g_ctr
      AST_CENTRE_ON: assert property (@(posedge clk) disable iff (rst)
        (simple_fam && !prog_en) |=> pad_oe[g]); // R9
    end else begin : g_outer
      AST_DIN_OFF: assert property (@(posedge clk) disable iff (rst)
        (simple_fam && cfg_loc[g] && !prog_en) |=> !pad_oe[g]); // R8
    end
  end

endmodule

bind pla_macro_array pla_macro_array_chk #(.N_MC(N_MC)) i_chk (.*);

// File: tb/test_pla_macro_array.sv
module test_pla_macro_array;

  localparam int NT   = 64;
  localparam int NL   = 40;
  localparam int FB   = NT * NL;
  localparam int CFGN = FB + 18;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       prog_en = 1'b0;
  logic       prog_sdi = 1'b0;
  logic [9:0] din = '0;
  logic       pin_ck = 1'b0;
  logic       pin_oen = 1'b0;
  logic       preload_en = 1'b0;
  logic [7:0] preload_val = '0;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;

  int n_tot = 0;
  int n_bad = 0;

  bit [FB-1:0] fz;
  bit [7:0]    m_pol;
  bit [7:0]    m_loc;
  bit [1:0]    m_gsel;
  bit [7:0]    mq;
  bit [7:0]    moe;

  always #2 clk = ~clk;

  pla_macro_array i_pla_macro_array (
    .clk(clk), .rst(rst), .prog_en(prog_en), .prog_sdi(prog_sdi),
    .din(din), .pin_ck(pin_ck), .pin_oen(pin_oen),
    .preload_en(preload_en), .preload_val(preload_val),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step(input bit [9:0] d, input bit ck, input bit oen,
                            input bit [7:0] pin, input bit pre, input bit [7:0] pv);
    int gm;
    int cm [8];
    bit [7:0]  fbv;
    bit [19:0] sig;
    bit [NT-1:0] pt;
    bit [7:0] nq, noe;
    gm = (m_gsel == 2'b01) ? 1 : (m_gsel == 2'b10) ? 2 : 0;
    for (int i = 0; i < 8; i++) begin
      bit ctr;
      ctr = (i == 3) || (i == 4);
      if (gm == 1)      cm[i] = m_loc[i] ? 0 : 1;
      else if (gm == 2) cm[i] = 1;
      else              cm[i] = (m_loc[i] && !ctr) ? 3 : 2;
      if (cm[i] == 0)      fbv[i] = mq[i];
      else if (cm[i] == 2) fbv[i] = ctr ? 1'b0 : pin[i];
      else                 fbv[i] = pin[i];
    end
    sig = {fbv, (gm == 1) ? 1'b0 : oen, (gm == 1) ? 1'b0 : ck, d};
    for (int t = 0; t < NT; t++) begin
      pt[t] = 1'b1;
      for (int l = 0; l < NL; l++) begin
        bit v;
        v = l[0] ? ~sig[l/2] : sig[l/2];
        if (fz[t*NL+l] && !v) pt[t] = 1'b0;
      end
    end
    for (int i = 0; i < 8; i++) begin
      bit s, dv;
      s = 1'b0;
      for (int k = (cm[i] == 1) ? 1 : 0; k < 8; k++) s = s | pt[i*8+k];
      dv = s ^ m_pol[i];
      if (pre)             nq[i] = pv[i];
      else if (cm[i] == 0) nq[i] = ck ? dv : mq[i];
      else                 nq[i] = dv;
      case (cm[i])
        0:       noe[i] = ~oen;
        1:       noe[i] = pt[i*8];
        2:       noe[i] = 1'b1;
        default: noe[i] = 1'b0;
      endcase
    end
    mq  = nq;
    moe = noe;
  endtask

  task automatic run_cycle(input bit [9:0] d, input bit ck, input bit oen, input bit [7:0] ext,
                           input bit pre, input bit [7:0] pv, input string tag);
    bit [7:0] pin;
    pin = (moe & mq) | (~moe & ext);
    din = d; pin_ck = ck; pin_oen = oen; pad_in = pin;
    preload_en = pre; preload_val = pv;
    model_step(d, ck, oen, pin, pre, pv);
    @(negedge clk);
    chk({tag, " pad_out"}, 32'(pad_out), 32'(mq));
    chk({tag, " pad_oe"}, 32'(pad_oe), 32'(moe));
  endtask

  task automatic program_cfg();
    bit [CFGN-1:0] v;
    v = {m_gsel, m_loc, m_pol, fz};
    for (int b = 0; b < CFGN; b++) begin
      prog_en = 1'b1;
      prog_sdi = v[b];
      @(negedge clk);
      if (b == 20) chk("R2 hi-z while shifting", 32'(pad_oe), 32'h0);
    end
    prog_en = 1'b0;
    preload_en = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R12 reset out", 32'(pad_out), 32'h0);
    chk("R12 reset oe", 32'(pad_oe), 32'h0);
    rst = 1'b0;
    mq = '0;
    moe = '0;
  endtask

  task automatic rand_cfg(input bit [1:0] gs);
    fz = '0;
    for (int t = 0; t < NT; t++) begin
      if ($urandom % 16 != 0) begin
        for (int j = 0; j < 3; j++) fz[t*NL + ($urandom % NL)] = 1'b1;
      end
    end
    m_pol = 8'($urandom);
    m_loc = 8'($urandom);
    m_gsel = gs;
  endtask

  task automatic run_random(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      run_cycle(10'($urandom), ($urandom % 4) != 0, ($urandom % 4) == 0, 8'($urandom),
                ($urandom % 16) == 0, 8'($urandom), tag);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_tot++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;

    // Directed: simple family, fixed-value terms, centre cells, dedicated input
    fz = '0;
    for (int t = 24; t < 32; t++) for (int l = 0; l < NL; l++) fz[t*NL+l] = 1'b1;
    for (int t = 33; t < 40; t++) for (int l = 0; l < NL; l++) fz[t*NL+l] = 1'b1;
    for (int t = 1; t < 8; t++)   for (int l = 0; l < NL; l++) fz[t*NL+l] = 1'b1;
    for (int t = 17; t < 24; t++) for (int l = 0; l < NL; l++) fz[t*NL+l] = 1'b1;
    fz[0*NL + 31]  = 1'b1;   // cell 0 term: complement of feedback of cell 3
    fz[16*NL + 26] = 1'b1;   // cell 2 term: true feedback of cell 1
    m_pol  = 8'b0000_1000;
    m_loc  = 8'b1111_1010;
    m_gsel = 2'b00;
    program_cfg();
    run_cycle(10'h0, 1'b0, 1'b0, 8'b0000_1010, 1'b0, 8'h0, "R4 directed");
    chk("R1 layout enables", 32'(pad_oe), 32'h1D);
    chk("R8 dedicated input off", 32'(pad_oe[1]), 32'h0);
    chk("R9 centre enabled", 32'(pad_oe[4:3]), 32'h3);
    chk("R3 all-connected term reads 0, R10 inverted", 32'(pad_out[3]), 32'h1);
    chk("R3 empty term reads 1", 32'(pad_out[4]), 32'h1);
    chk("R9 centre feedback reads 0", 32'(pad_out[0]), 32'h1);
    chk("R8 pin feedback high", 32'(pad_out[2]), 32'h1);
    run_cycle(10'h0, 1'b0, 1'b0, 8'b0000_1000, 1'b0, 8'h0, "R4 directed");
    chk("R8 pin feedback low", 32'(pad_out[2]), 32'h0);

    // Registered family
    rand_cfg(2'b01);
    program_cfg();
    run_random(300, "R6 registered");
    run_cycle(10'h3, 1'b1, 1'b0, 8'h0, 1'b1, 8'hA5, "R11 preload");
    chk("R11 preload value", 32'(pad_out), 32'hA5);
    m_loc = 8'hFF;
    program_cfg();
    run_cycle(10'h155, 1'b0, 1'b1, 8'h0, 1'b1, 8'h3C, "R11 preload");
    run_cycle(10'h2AA, 1'b0, 1'b1, 8'hFF, 1'b0, 8'h0, "R6 hold");
    chk("R6 hold with strobe low", 32'(pad_out), 32'h3C);
    chk("R6 shared enable off", 32'(pad_oe), 32'h0);
    run_random(200, "R6 registered");

    // Wide-I/O family
    rand_cfg(2'b10);
    program_cfg();
    run_random(300, "R7 wide io");

    // Simple family via both codes
    rand_cfg(2'b00);
    program_cfg();
    run_random(200, "R4 simple");
    rand_cfg(2'b11);
    program_cfg();
    run_random(200, "R5 code 11 as simple");
    m_pol = ~m_pol;
    program_cfg();
    run_random(100, "R10 polarity flipped");

    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

endmodule